// File: doc/BRIEF.md
# Codec Power-Domain Sequencer

This block controls how the digital side of a mixed-signal audio codec is brought up and shut down. A small set of write-only control registers holds a global power enable, memory keep options for two DSP cores, a common-mode keep-alive choice and a fast-charge override. It also holds requests for the PLL, the crystal, the two DSP cores and a bank of signal-path blocks, a master block enable, and the masks for two interrupt lines. From these registers, a PLL lock input and a 1 ms tick, the block drives the supply and retention controls of each domain. It also drives the common-mode reference, a set of gated enables for each block, a power-up-complete flag and two interrupt lines.

The common-mode reference has to charge before anything analog may start. A saturating millisecond counter tracks this charge. It runs while the reference is powered and clears when the reference is lost. The PLL and crystal enables are held back until the count reaches its limit. If the reference was kept alive across a power-down, it is still charged, so a later power-up gets the PLL at once. A hardware power-down pin, active low, acts as a full synchronous reset alongside the system reset.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst` is 1 or `pd_n` is 0, every register returns to its reset value and register writes are ignored. Reset values: all enables and keep bits 0, both interrupt masks 1, status 0, charge count 0. All outputs are then 0.
- R2: Register writes use address 0 (power) with bit 0 as the global power enable and bit 2 as the fast-charge override. They use address 1 (keep) with bit 0 as the DSP B keep, bit 1 as the DSP A keep and bit 4 as the common-mode keep-alive. `dig_pwr` equals the global power enable. `mem_a_pwr` is the global power enable OR the DSP A keep, and `mem_b_pwr` is the global power enable OR the DSP B keep.
- R3: `cm_en` is the global power enable OR the common-mode keep-alive. `cm_fast` is `cm_en` AND NOT the fast-charge override.
- R4: A charge counter advances by one on each cycle with `ms_tick` high while `cm_en` is 1, and saturates at WAIT_MS (35). It returns to 0 on any cycle that starts with `cm_en` at 0. The reference counts as charged only when the count equals WAIT_MS.
- R5: Address 2 holds the PLL request (bit 0), crystal request (bit 1), DSP A request (bit 2), DSP B request (bit 3) and master block enable (bit 7). `pll_en` and `xtal_en` are their requests ANDed with the global power enable and the charged state.
- R6: If the keep-alive is 1 when the global enable drops, a charged reference stays charged. Re-asserting the global enable then gives `pll_en` with no further ticks.
- R7: `dsp_a_en` and `dsp_b_en` are their requests ANDed with the global power enable, whatever the master enable is.
- R8: `blk_en[i]` is bit i of the address-3 request register, ANDed with the master enable, the global power enable and the charged state.
- R9: `pwr_done` becomes 1 one clock after the first edge at which the global enable, the charged state, the PLL request and `pll_locked` are all 1. Staying in that condition does not set it again.
- R10: `irq[k]` is `pwr_done` AND NOT mask k. The masks are address 4 bits 0 and 1, and both reset to 1.
- R11: Writing address 4 with bit 7 set clears `pwr_done` on the next edge, unless a new completion edge happens in that same cycle, which wins.
- R12: `pwr_done` returns to 0 on the first edge after the global power enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Hardware power-down, low forces full reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pll_locked | input | 1 | PLL lock indication |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| dig_pwr | output | 1 | Supply gate for the main digital domains |
| mem_a_pwr | output | 1 | Supply for DSP A program/parameter memories |
| mem_b_pwr | output | 1 | Supply for DSP B program/parameter memories |
| cm_en | output | 1 | Common-mode reference enable |
| cm_fast | output | 1 | Common-mode fast-charge control |
| pll_en | output | 1 | Effective PLL enable |
| xtal_en | output | 1 | Effective crystal enable |
| dsp_a_en | output | 1 | Effective DSP A enable |
| dsp_b_en | output | 1 | Effective DSP B enable |
| blk_en | output | 8 | Effective signal-path block enables |
| pwr_done | output | 1 | Power-up-complete status |
| irq | output | 2 | Interrupt lines, level |

## Verification
The bench probes the charge counter at the boundary, after 34 ticks and after the 35th. A counter with an off-by-one would release the PLL one millisecond early or late. It also power-cycles with the keep-alive set and again with it clear. A design that cleared the count on every power-down would stall the PLL in the first case, and one that kept it would skip the wait in the second. The completion flag is cleared by write-one while the lock stays high. A level-set design would reassert it at once. The flag is also checked for dropping when power goes off. Finally, writes issued while the power-down pin is low must leave no trace once it rises.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    parameter int BLK_W  = 8;
    parameter int IRQ_N  = 2;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PWR  = 3'd0,
        A_KEEP = 3'd1,
        A_CORE = 3'd2,
        A_BLK  = 3'd3,
        A_IRQ  = 3'd4
    } reg_addr_e;

    // field positions inside the write data
    localparam int B_GPE    = 0;
    localparam int B_CMOVER = 2;
    localparam int B_KEEPB  = 0;
    localparam int B_KEEPA  = 1;
    localparam int B_CMKEEP = 4;
    localparam int B_PLL    = 0;
    localparam int B_XTAL   = 1;
    localparam int B_DSPA   = 2;
    localparam int B_DSPB   = 3;
    localparam int B_MASTER = 7;
    localparam int B_W1C    = 7;

    typedef struct packed {
        logic pll;
        logic xtal;
        logic dsp_a;
        logic dsp_b;
    } core_t;

    typedef struct packed {
        logic              gpe;
        logic              cm_over;
        logic              keep_a;
        logic              keep_b;
        logic              cm_keep;
        core_t             core_req;
        logic              master;
        logic [BLK_W-1:0]  blk_req;
        logic [IRQ_N-1:0]  mask;
    } ctl_t;

    function automatic ctl_t ctl_reset();
        ctl_t c;
        c          = '0;
        c.mask     = '1;
        return c;
    endfunction

    function automatic core_t core_gate(core_t req, logic gpe, logic ready);
        core_t o;
        o.pll   = req.pll   & gpe & ready;
        o.xtal  = req.xtal  & gpe & ready;
        o.dsp_a = req.dsp_a & gpe;
        o.dsp_b = req.dsp_b & gpe;
        return o;
    endfunction
endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
    import pwrseq_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl,
    output logic              w1c
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            ctl_q <= ctl_reset();
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_PWR: begin
                    ctl_q.gpe     <= wr_data[B_GPE];
                    ctl_q.cm_over <= wr_data[B_CMOVER];
                end
                A_KEEP: begin
                    ctl_q.keep_a  <= wr_data[B_KEEPA];
                    ctl_q.keep_b  <= wr_data[B_KEEPB];
                    ctl_q.cm_keep <= wr_data[B_CMKEEP];
                end
                A_CORE: begin
                    ctl_q.core_req.pll   <= wr_data[B_PLL];
                    ctl_q.core_req.xtal  <= wr_data[B_XTAL];
                    ctl_q.core_req.dsp_a <= wr_data[B_DSPA];
                    ctl_q.core_req.dsp_b <= wr_data[B_DSPB];
                    ctl_q.master         <= wr_data[B_MASTER];
                end
                A_BLK:   ctl_q.blk_req <= wr_data[BLK_W-1:0];
                A_IRQ:   ctl_q.mask    <= wr_data[IRQ_N-1:0];
                default: ;
            endcase
        end
    end

    assign ctl = ctl_q;
    assign w1c = wr_en && (wr_addr == A_IRQ) && wr_data[B_W1C];

    // R2: the global enable only moves on a power-register write
    p_gpe_hold_r2: assert property (@(posedge clk) disable iff (srst)
        !(wr_en && wr_addr == A_PWR) |=> $stable(ctl_q.gpe));

    // R10: masks only move on an interrupt-register write
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (srst)
        !(wr_en && wr_addr == A_IRQ) |=> $stable(ctl_q.mask));
endmodule

// File: rtl/pwrseq_cmtimer.sv
module pwrseq_cmtimer #(
    parameter int WAIT_MS = 35
) (
    input  logic clk,
    input  logic srst,
    input  logic cm_on,
    input  logic tick,
    output logic ready
);
    localparam int CW = $clog2(WAIT_MS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_MS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (srst || !cm_on) begin
            cnt <= '0;
        end else if (tick && cnt < LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == LIMIT);

    // R4: never beyond the limit
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (srst)
        cnt <= LIMIT);

    // R4: a tick below the limit advances by exactly one
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (srst)
        (cm_on && tick && cnt < LIMIT) |=> cnt == $past(cnt) + 1'b1);

    // R4: losing the reference discards the charge
    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (srst)
        !cm_on |=> cnt == '0);
endmodule

// File: rtl/pwrseq_gate.sv
module pwrseq_gate
    import pwrseq_pkg::*;
(
    input  logic             gpe,
    input  logic             ready,
    input  logic             master,
    input  core_t            core_req,
    input  logic [BLK_W-1:0] blk_req,
    output core_t            core_en,
    output logic [BLK_W-1:0] blk_en
);
    logic blk_allow;

    assign core_en   = core_gate(core_req, gpe, ready);
    assign blk_allow = master & gpe & ready;

    for (genvar i = 0; i < BLK_W; i++) begin : g_blk
        assign blk_en[i] = blk_req[i] & blk_allow;
    end
endmodule

// File: rtl/pwrseq_status.sv
module pwrseq_status #(
    parameter int IRQ_N = 2
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             gpe,
    input  logic             done_cond,
    input  logic             w1c,
    input  logic [IRQ_N-1:0] mask,
    output logic             status,
    output logic [IRQ_N-1:0] irq
);
    logic done_prev;
    logic set_evt;

    assign set_evt = done_cond & ~done_prev;

    always_ff @(posedge clk) begin
        if (srst) begin
            status    <= 1'b0;
            done_prev <= 1'b0;
        end else begin
            done_prev <= done_cond;
            if (!gpe)         status <= 1'b0;
            else if (set_evt) status <= 1'b1;
            else if (w1c)     status <= 1'b0;
        end
    end

    for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
        assign irq[k] = status & ~mask[k];
    end

    // R12: status is gone one edge after power drops
    p_stat_drop_r12: assert property (@(posedge clk) disable iff (srst)
        !gpe |=> !status);

    // R11: a clear with no new completion edge wins
    p_stat_w1c_r11: assert property (@(posedge clk) disable iff (srst)
        (w1c && !set_evt) |=> !status);

    // R9: a rising status always comes from a completion edge
    p_stat_cause_r9: assert property (@(posedge clk) disable iff (srst)
        $rose(status) |-> $past(done_cond));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int WAIT_MS = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pll_locked,
    input  logic              ms_tick,
    output logic              dig_pwr,
    output logic              mem_a_pwr,
    output logic              mem_b_pwr,
    output logic              cm_en,
    output logic              cm_fast,
    output logic              pll_en,
    output logic              xtal_en,
    output logic              dsp_a_en,
    output logic              dsp_b_en,
    output logic [BLK_W-1:0]  blk_en,
    output logic              pwr_done,
    output logic [IRQ_N-1:0]  irq
);
    logic  srst;
    ctl_t  ctl;
    logic  w1c;
    logic  ready;
    core_t core_en;
    logic  done_cond;

    assign srst = rst | ~pd_n;

    pwrseq_regs u_regs (
        .clk     (clk),
        .srst    (srst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl     (ctl),
        .w1c     (w1c)
    );

    assign dig_pwr   = ctl.gpe;
    assign mem_a_pwr = ctl.gpe | ctl.keep_a;
    assign mem_b_pwr = ctl.gpe | ctl.keep_b;
    assign cm_en     = ctl.gpe | ctl.cm_keep;
    assign cm_fast   = cm_en & ~ctl.cm_over;

    pwrseq_cmtimer #(.WAIT_MS(WAIT_MS)) u_timer (
        .clk   (clk),
        .srst  (srst),
        .cm_on (cm_en),
        .tick  (ms_tick),
        .ready (ready)
    );

    pwrseq_gate u_gate (
        .gpe      (ctl.gpe),
        .ready    (ready),
        .master   (ctl.master),
        .core_req (ctl.core_req),
        .blk_req  (ctl.blk_req),
        .core_en  (core_en),
        .blk_en   (blk_en)
    );

    assign pll_en   = core_en.pll;
    assign xtal_en  = core_en.xtal;
    assign dsp_a_en = core_en.dsp_a;
    assign dsp_b_en = core_en.dsp_b;

    assign done_cond = pll_en & pll_locked;

    pwrseq_status #(.IRQ_N(IRQ_N)) u_status (
        .clk       (clk),
        .srst      (srst),
        .gpe       (ctl.gpe),
        .done_cond (done_cond),
        .w1c       (w1c),
        .mask      (ctl.mask),
        .status    (pwr_done),
        .irq       (irq)
    );

    // R5: analog clocking never starts before the reference is charged
    p_pll_wait_r5: assert property (@(posedge clk) disable iff (srst)
        (pll_en || xtal_en) |-> ready);

    // R8: with master low no signal-path block runs
    p_blk_master_r8: assert property (@(posedge clk) disable iff (srst)
        !ctl.master |-> blk_en == '0);

    // R2: digital domains off means no block and no DSP runs
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (srst)
        !dig_pwr |-> (!dsp_a_en && !dsp_b_en && !pll_en && blk_en == '0));
endmodule

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;
    localparam int W = 35;

    logic       clk = 0;
    logic       rst = 1;
    logic       pd_n = 1;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       pll_locked = 0;
    logic       ms_tick = 0;
    logic       dig_pwr, mem_a_pwr, mem_b_pwr, cm_en, cm_fast;
    logic       pll_en, xtal_en, dsp_a_en, dsp_b_en, pwr_done;
    logic [7:0] blk_en;
    logic [1:0] irq;

    int n_chk = 0;
    int n_err = 0;
    bit started = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwrseq_top dut (
        .clk(clk), .rst(rst), .pd_n(pd_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pll_locked(pll_locked), .ms_tick(ms_tick),
        .dig_pwr(dig_pwr), .mem_a_pwr(mem_a_pwr), .mem_b_pwr(mem_b_pwr),
        .cm_en(cm_en), .cm_fast(cm_fast), .pll_en(pll_en), .xtal_en(xtal_en),
        .dsp_a_en(dsp_a_en), .dsp_b_en(dsp_b_en), .blk_en(blk_en),
        .pwr_done(pwr_done), .irq(irq)
    );

    // behavioural reference state
    bit m_gpe, m_over, m_ka, m_kb, m_ck, m_master, m_stat, m_dprev;
    bit [3:0] m_core;
    bit [7:0] m_blk;
    bit [1:0] m_mask = 2'b11;
    int m_cnt;

    always @(posedge clk) begin
        if (rst || !pd_n) begin
            m_gpe = 0; m_over = 0; m_ka = 0; m_kb = 0; m_ck = 0; m_master = 0;
            m_core = 0; m_blk = 0; m_mask = 2'b11; m_cnt = 0; m_stat = 0; m_dprev = 0;
        end else begin
            bit cm_on, rdy, dc, clr;
            cm_on = m_gpe || m_ck;
            rdy   = (m_cnt == W);
            dc    = m_gpe && rdy && m_core[0] && pll_locked;
            clr   = wr_en && wr_addr == 3'd4 && wr_data[7];
            if (!cm_on) m_cnt = 0;
            else if (ms_tick && m_cnt < W) m_cnt = m_cnt + 1;
            if (!m_gpe) m_stat = 0;
            else if (dc && !m_dprev) m_stat = 1;
            else if (clr) m_stat = 0;
            m_dprev = dc;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_gpe = wr_data[0]; m_over = wr_data[2]; end
                    3'd1: begin m_kb = wr_data[0]; m_ka = wr_data[1]; m_ck = wr_data[4]; end
                    3'd2: begin m_core = wr_data[3:0]; m_master = wr_data[7]; end
                    3'd3: m_blk = wr_data;
                    3'd4: m_mask = wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (started && !finished) begin
            bit rdy, cm;
            rdy = (m_cnt == W);
            cm  = m_gpe || m_ck;
            chk("R2 domains", {dig_pwr, mem_a_pwr, mem_b_pwr},
                {m_gpe, m_gpe || m_ka, m_gpe || m_kb});
            chk("R3 cm", {cm_en, cm_fast}, {cm, cm && !m_over});
            chk("R5 pll/xtal", {pll_en, xtal_en},
                {m_core[0] && m_gpe && rdy, m_core[1] && m_gpe && rdy});
            chk("R7 dsp", {dsp_a_en, dsp_b_en}, {m_core[2] && m_gpe, m_core[3] && m_gpe});
            chk("R8 blk", blk_en, m_blk & {8{m_master && m_gpe && rdy}});
            chk("R9 done", pwr_done, m_stat);
            chk("R10 irq", irq, {2{m_stat}} & ~m_mask);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_addr = 0; wr_data = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1; @(negedge clk);
            ms_tick = 0; @(negedge clk);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        started = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {dig_pwr, mem_a_pwr, mem_b_pwr, cm_en, cm_fast, pll_en,
            xtal_en, dsp_a_en, dsp_b_en, blk_en, pwr_done, irq}, 0);
        wr(3'd1, 8'h02);                       // keep A only
        chk("R2 mem retention off", {dig_pwr, mem_a_pwr, mem_b_pwr}, 3'b010);
        wr(3'd2, 8'h07);                       // pll, xtal, dsp A requests
        wr(3'd3, 8'hA5);
        chk("R7 dsp off while unpowered", dsp_a_en, 0);
        wr(3'd0, 8'h01);                       // power on, fast charge
        chk("R3 fast charge", {cm_en, cm_fast}, 2'b11);
        chk("R7 dsp on ignores master", {dsp_a_en, dsp_b_en}, 2'b10);
        ticks(W - 1);
        chk("R4 before limit", pll_en, 0);
        ticks(1);
        chk("R5 pll and xtal after charge", {pll_en, xtal_en}, 2'b11);
        chk("R8 master low", blk_en, 0);
        wr(3'd0, 8'h05);                       // startup over
        chk("R3 low-power charge", cm_fast, 0);
        wr(3'd4, 8'h02);                       // unmask line 0
        pll_locked = 1;
        @(negedge clk);
        chk("R9 complete", pwr_done, 1);
        chk("R10 irq line0 only", irq, 2'b01);
        wr(3'd4, 8'h82);                       // write-one-to-clear
        @(negedge clk);
        chk("R11 cleared while locked", pwr_done, 0);
        wr(3'd2, 8'h87);
        chk("R8 master high", blk_en, 8'hA5);
        pll_locked = 0; @(negedge clk);
        pll_locked = 1; @(negedge clk);
        chk("R9 second event", pwr_done, 1);
        wr(3'd1, 8'h12);                       // keep alive
        wr(3'd0, 8'h04);                       // power off
        @(negedge clk);
        chk("R12 done drops", {pwr_done, irq}, 0);
        chk("R3 cm kept", cm_en, 1);
        wr(3'd0, 8'h05);
        chk("R6 no wait with keep alive", pll_en, 1);
        wr(3'd1, 8'h02);                       // drop keep alive
        wr(3'd0, 8'h04);
        @(negedge clk);
        wr(3'd0, 8'h05);
        chk("R4 wait restarts", pll_en, 0);
        ticks(W);
        chk("R4 wait completes", pll_en, 1);
        wr(3'd4, 8'h03);                       // both masked
        pll_locked = 0; @(negedge clk);
        pll_locked = 1; @(negedge clk);
        chk("R10 masked lines", {pwr_done, irq}, 3'b100);
        pll_locked = 0;
        wr(3'd4, 8'h81);
        wr(3'd4, 8'h01);                       // unmask line 1
        pll_locked = 1; wr(3'd4, 8'h81);       // clear and completion edge together
        chk("R11 set wins over clear", {pwr_done, irq}, 3'b110);
        pd_n = 0;
        wr(3'd1, 8'h13);
        wr(3'd0, 8'h01);
        chk("R1 power-down pin", {dig_pwr, mem_a_pwr, cm_en, pll_en, pwr_done}, 0);
        pd_n = 1;
        @(negedge clk);
        chk("R1 writes ignored in power-down", {dig_pwr, mem_a_pwr, mem_b_pwr, cm_en}, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule